// File: doc/BRIEF.md
# Bridge downstream address decoder

This block sits on the host side of a PCI-to-PCI style bridge and decides, one request at a time, whether a memory or I/O request should pass to the secondary bus. It compares I/O requests against a programmed I/O window whose base and limit are kept at 4 KB granularity. It can also pass the legacy video memory and I/O ranges, and it can narrow the I/O window to the first quarter of each 1 KB block, as legacy add-in decoding requires. Memory requests are passed only through the legacy video range, because prefetchable and plain memory windows are handled elsewhere.

A second, independent path looks at requests that arrive from the secondary side. It flags the ones that fall in the legacy video ranges so that the bridge leaves them unclaimed. Both decisions are registered and appear one clock after the request, each with its own valid strobe. A small write port loads the window base, the window limit and three control bits.

Top module: `brdec_top`

## Requirements
- R1: `fwd_valid` is high in exactly the cycle after a cycle with `req_valid` high. `fwd_hit` is low whenever `fwd_valid` is low.
- R2: With video enable set, a memory request (`req_is_io`=0) to an address from 000A_0000h to 000B_FFFFh inclusive gives `fwd_hit`=1. A memory request outside that range, or any memory request while video enable is clear, gives `fwd_hit`=0.
- R3: With video enable set, an I/O request is passed when address bits [9:0] lie in 3B0h–3BBh or in 3C0h–3DFh and bits [31:16] are zero. The neighbours 3AFh, 3BCh and 3E0h are not passed by this rule.
- R4: With 16-bit video decode set, the video I/O match also needs address bits [15:10] to be zero. With it clear, those bits are ignored, so 07C0h matches.
- R5: With ISA mode clear, an I/O request is passed when its address lies between base[31:12]:000h and limit[31:12]:FFFh inclusive. When base is greater than limit, no address is in the window.
- R6: With ISA mode set, a window address below 10000h is passed only when bits [9:8] are 00. Window addresses at or above 10000h are passed as in R5.
- R7: `sec_rsp_valid` follows `sec_valid` by one clock. `sec_noclaim` is 1 exactly when video enable is set and the secondary request hits the video memory or video I/O range, using the same rules as R2–R4.
- R8: After reset all three control bits are 0, the base is FFFF_F000h and the limit is 0. With these values no request is passed and no secondary request is flagged.
- R9: A write with `cfg_wr_sel` 0 loads the base and a write with 1 loads the limit; only bits [31:12] are kept in both cases. A write with 2 loads the controls: bit 0 is video enable, bit 1 is 16-bit video decode, bit 2 is ISA mode. A write with 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Write target: 0 base, 1 limit, 2 controls, 3 none |
| cfg_wr_data | input | 32 | Write data |
| req_valid | input | 1 | Host-side request present |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 32 | Host-side request address |
| sec_valid | input | 1 | Secondary-side request present |
| sec_is_io | input | 1 | 1 = I/O, 0 = memory, secondary side |
| sec_addr | input | 32 | Secondary-side request address |
| fwd_valid | output | 1 | Forward decision valid |
| fwd_hit | output | 1 | Request is passed to the secondary bus |
| sec_rsp_valid | output | 1 | Secondary decision valid |
| sec_noclaim | output | 1 | Secondary request must not be claimed |

## Verification
The assertions assume that the control bits seen in a request cycle are the ones that apply to that request. They also assume that the memory-path and ISA-filter properties apply only when video enable does not add a hit of its own. The bench keeps within this: every configuration write finishes at least one full clock before the next request is driven, and the ISA checks run with video enable clear. Requests are held for exactly one cycle, so each registered decision can be matched to the request that caused it.

// File: rtl/brdec_pkg.sv
// Shared types for the bridge downstream decoder.
// Assumes a 32-bit host address space.
package brdec_pkg;
    localparam int ADDR_W = 32;

    // Write-port target selector
    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_LIMIT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    // Control bits; packed so isa_en is bit 2, vga16 bit 1, vga_en bit 0
    typedef struct packed {
        logic isa_en;
        logic vga16;
        logic vga_en;
    } ctrl_t;
endpackage

// File: rtl/brdec_regs.sv
// Configuration storage: I/O window base/limit page numbers and control bits.
// Assumes one write per cycle; page fields keep only bits above GRAN_BITS.
module brdec_regs
    import brdec_pkg::*;
#(
    parameter int AW        = 32,
    parameter int GRAN_BITS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [AW-1:0]      wr_data,
    output logic [AW-GRAN_BITS-1:0] base_pg,
    output logic [AW-GRAN_BITS-1:0] limit_pg,
    output ctrl_t              ctrl
);
    localparam int PG_W = AW - GRAN_BITS;

    logic unused_low;
    assign unused_low = ^{wr_data[GRAN_BITS-1:3]};

    // Register update on a write strobe; reset leaves the window empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_pg  <= {PG_W{1'b1}};
            limit_pg <= '0;
            ctrl     <= '0;
        end else if (wr_en) begin
            case (cfg_sel_e'(wr_sel))
                SEL_BASE:  base_pg  <= wr_data[AW-1:GRAN_BITS];
                SEL_LIMIT: limit_pg <= wr_data[AW-1:GRAN_BITS];
                SEL_CTRL:  ctrl     <= ctrl_t'(wr_data[2:0]);
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/brdec_window.sv
// I/O window match with optional ISA filtering.
// Assumes base/limit are page numbers; window is empty when base > limit.
module brdec_window #(
    parameter int AW             = 32,
    parameter int GRAN_BITS      = 12,
    parameter int LOW_SPACE_BITS = 16,
    parameter int BLOCK_BITS     = 10,
    parameter int KEEP_BITS      = 8
) (
    input  logic                    is_io,
    input  logic [AW-1:0]           addr,
    input  logic [AW-GRAN_BITS-1:0] base_pg,
    input  logic [AW-GRAN_BITS-1:0] limit_pg,
    input  logic                    isa_en,
    output logic                    hit
);
    logic [AW-GRAN_BITS-1:0] pg;
    logic in_win, low_space, keep_part;
    logic unused_mid;

    assign unused_mid = ^{addr[GRAN_BITS-1:BLOCK_BITS], addr[KEEP_BITS-1:0]};

    // Page compare, low-space test and block-offset test
    always_comb begin
        pg        = addr[AW-1:GRAN_BITS];
        in_win    = (pg >= base_pg) && (pg <= limit_pg);
        low_space = (addr[AW-1:LOW_SPACE_BITS] == '0);
        keep_part = (addr[BLOCK_BITS-1:KEEP_BITS] == '0);
        hit       = is_io && in_win && !(isa_en && low_space && !keep_part);
    end
endmodule

// File: rtl/brdec_vga.sv
// Legacy video range match for memory and I/O requests.
// Assumes AW >= 20; I/O match needs upper 16 bits zero.
module brdec_vga #(
    parameter int AW = 32
) (
    input  logic          is_io,
    input  logic [AW-1:0] addr,
    input  logic          vga_en,
    input  logic          vga16,
    output logic          hit
);
    localparam logic [AW-1:0] MEM_LO = AW'(32'h000A_0000);
    localparam logic [AW-1:0] MEM_HI = AW'(32'h000B_FFFF);

    logic [9:0] low10;
    logic mem_hit, io_rng, io_upper, io_mid;

    // Range tests for the video memory hole and the two I/O groups
    always_comb begin
        low10    = addr[9:0];
        mem_hit  = (addr >= MEM_LO) && (addr <= MEM_HI);
        io_rng   = ((low10 >= 10'h3B0) && (low10 <= 10'h3BB)) ||
                   ((low10 >= 10'h3C0) && (low10 <= 10'h3DF));
        io_upper = (addr[AW-1:16] == '0);
        io_mid   = !vga16 || (addr[15:10] == '0);
        hit      = vga_en && (is_io ? (io_rng && io_upper && io_mid) : mem_hit);
    end
endmodule

// File: rtl/brdec_top.sv
// Bridge downstream address decoder top: registered forward decision for
// host requests and registered no-claim flag for secondary requests.
// Assumes single-cycle request strobes.
module brdec_top
    import brdec_pkg::*;
#(
    parameter int AW        = brdec_pkg::ADDR_W,
    parameter int GRAN_BITS = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr_en,
    input  logic [1:0]    cfg_wr_sel,
    input  logic [AW-1:0] cfg_wr_data,
    input  logic          req_valid,
    input  logic          req_is_io,
    input  logic [AW-1:0] req_addr,
    input  logic          sec_valid,
    input  logic          sec_is_io,
    input  logic [AW-1:0] sec_addr,
    output logic          fwd_valid,
    output logic          fwd_hit,
    output logic          sec_rsp_valid,
    output logic          sec_noclaim
);
    localparam int PG_W = AW - GRAN_BITS;

    logic [PG_W-1:0] base_pg, limit_pg;
    ctrl_t ctrl;
    logic  cfg_vga_en, cfg_isa_en;
    logic  win_hit, host_vga_hit, sec_vga_hit;

    assign cfg_vga_en = ctrl.vga_en;
    assign cfg_isa_en = ctrl.isa_en;

    brdec_regs #(.AW(AW), .GRAN_BITS(GRAN_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
        .wr_data(cfg_wr_data), .base_pg(base_pg), .limit_pg(limit_pg),
        .ctrl(ctrl)
    );

    brdec_window #(.AW(AW), .GRAN_BITS(GRAN_BITS)) u_win (
        .is_io(req_is_io), .addr(req_addr), .base_pg(base_pg),
        .limit_pg(limit_pg), .isa_en(ctrl.isa_en), .hit(win_hit)
    );

    brdec_vga #(.AW(AW)) u_vga_host (
        .is_io(req_is_io), .addr(req_addr), .vga_en(ctrl.vga_en),
        .vga16(ctrl.vga16), .hit(host_vga_hit)
    );

    brdec_vga #(.AW(AW)) u_vga_sec (
        .is_io(sec_is_io), .addr(sec_addr), .vga_en(ctrl.vga_en),
        .vga16(ctrl.vga16), .hit(sec_vga_hit)
    );

    // Register the host forward decision with its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_hit   <= 1'b0;
        end else begin
            fwd_valid <= req_valid;
            fwd_hit   <= req_valid && (win_hit || host_vga_hit);
        end
    end

    // Register the secondary no-claim flag with its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_rsp_valid <= 1'b0;
            sec_noclaim   <= 1'b0;
        end else begin
            sec_rsp_valid <= sec_valid;
            sec_noclaim   <= sec_valid && sec_vga_hit;
        end
    end
endmodule

// File: rtl/brdec_chk.sv
// Property checker for brdec_top, attached by bind.
module brdec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_is_io,
    input logic [31:0] req_addr,
    input logic        sec_valid,
    input logic        fwd_valid,
    input logic        fwd_hit,
    input logic        sec_rsp_valid,
    input logic        sec_noclaim,
    input logic        vga_en,
    input logic        isa_en
);
    logic mem_in_hole;
    assign mem_in_hole = (req_addr >= 32'h000A_0000) && (req_addr <= 32'h000B_FFFF);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> fwd_valid); // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !fwd_valid); // R1
    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_valid |-> !fwd_hit); // R1
    AST_VGA_MEM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && vga_en && mem_in_hole) |=> fwd_hit); // R2
    AST_MEM_ELSE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && !(vga_en && mem_in_hole)) |=> !fwd_hit); // R2
    AST_ISA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io && isa_en && !vga_en &&
         req_addr[31:16] == 16'h0 && req_addr[9:8] != 2'b00) |=> !fwd_hit); // R6
    AST_SEC_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |=> sec_rsp_valid); // R7
    AST_SEC_OFF_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_valid && !vga_en) |=> !sec_noclaim); // R7
endmodule

bind brdec_top brdec_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_addr(req_addr), .sec_valid(sec_valid), .fwd_valid(fwd_valid),
    .fwd_hit(fwd_hit), .sec_rsp_valid(sec_rsp_valid),
    .sec_noclaim(sec_noclaim), .vga_en(cfg_vga_en), .isa_en(cfg_isa_en)
);

// File: tb/tb_brdec_top.sv
`timescale 1ns/1ps
module tb_brdec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = 2'd0;
    logic [31:0] cfg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_is_io = 1'b0;
    logic [31:0] req_addr = '0;
    logic        sec_valid = 1'b0;
    logic        sec_is_io = 1'b0;
    logic [31:0] sec_addr = '0;
    logic        fwd_valid, fwd_hit, sec_rsp_valid, sec_noclaim;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    brdec_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .req_valid(req_valid), .req_is_io(req_is_io),
        .req_addr(req_addr), .sec_valid(sec_valid), .sec_is_io(sec_is_io),
        .sec_addr(sec_addr), .fwd_valid(fwd_valid), .fwd_hit(fwd_hit),
        .sec_rsp_valid(sec_rsp_valid), .sec_noclaim(sec_noclaim)
    );

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic wcfg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic host(input string rq, input logic io, input logic [31:0] a, input logic exp);
        @(negedge clk);
        req_valid = 1'b1; req_is_io = io; req_addr = a;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check(rq, $sformatf("valid @%h", a), {31'b0, fwd_valid}, 32'd1);
        check(rq, $sformatf("hit io=%0d @%h", io, a), {31'b0, fwd_hit}, {31'b0, exp});
    endtask

    task automatic sec(input string rq, input logic io, input logic [31:0] a, input logic exp);
        @(negedge clk);
        sec_valid = 1'b1; sec_is_io = io; sec_addr = a;
        @(posedge clk); #1;
        sec_valid = 1'b0;
        check(rq, $sformatf("sec valid @%h", a), {31'b0, sec_rsp_valid}, 32'd1);
        check(rq, $sformatf("noclaim io=%0d @%h", io, a), {31'b0, sec_noclaim}, {31'b0, exp});
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R8", "fwd_valid after reset", {31'b0, fwd_valid}, 0);
        check("R8", "sec_noclaim after reset", {31'b0, sec_noclaim}, 0);
        host("R8", 1'b0, 32'h000A_0000, 1'b0);
        host("R8", 1'b1, 32'h0000_03C0, 1'b0);
        host("R8", 1'b1, 32'h0000_0000, 1'b0);
        sec("R8", 1'b0, 32'h000B_0000, 1'b0);
    endtask

    task automatic t_idle();
        @(negedge clk); @(posedge clk); #1;
        check("R1", "idle fwd_valid", {31'b0, fwd_valid}, 0);
        check("R1", "idle fwd_hit", {31'b0, fwd_hit}, 0);
    endtask

    task automatic t_mem_vga();
        wcfg(2'd2, 32'h1);
        host("R2", 1'b0, 32'h000A_0000, 1'b1);
        host("R2", 1'b0, 32'h000B_FFFF, 1'b1);
        host("R2", 1'b0, 32'h0009_FFFF, 1'b0);
        host("R2", 1'b0, 32'h000C_0000, 1'b0);
    endtask

    task automatic t_io_vga(input logic v16);
        wcfg(2'd2, {29'b0, 1'b0, v16, 1'b1});
        host("R3", 1'b1, 32'h0000_03AF, 1'b0);
        host("R3", 1'b1, 32'h0000_03B0, 1'b1);
        host("R3", 1'b1, 32'h0000_03BB, 1'b1);
        host("R3", 1'b1, 32'h0000_03BC, 1'b0);
        host("R3", 1'b1, 32'h0000_03DF, 1'b1);
        host("R3", 1'b1, 32'h0000_03E0, 1'b0);
        host("R3", 1'b1, 32'h0001_03C0, 1'b0);
        host("R4", 1'b1, 32'h0000_07C0, !v16);
        host("R4", 1'b1, 32'h0000_FBB0, !v16);
    endtask

    task automatic t_window();
        wcfg(2'd2, 32'h0);
        wcfg(2'd0, 32'h0000_F000);
        wcfg(2'd1, 32'h0001_0000);
        host("R5", 1'b1, 32'h0000_EFFF, 1'b0);
        host("R5", 1'b1, 32'h0000_F000, 1'b1);
        host("R5", 1'b1, 32'h0000_F100, 1'b1);
        host("R5", 1'b1, 32'h0001_0FFF, 1'b1);
        host("R5", 1'b1, 32'h0001_1000, 1'b0);
        host("R5", 1'b0, 32'h0000_F100, 1'b0);
        wcfg(2'd2, 32'h4);
        host("R6", 1'b1, 32'h0000_F0FF, 1'b1);
        host("R6", 1'b1, 32'h0000_F100, 1'b0);
        host("R6", 1'b1, 32'h0000_FF00, 1'b0);
        host("R6", 1'b1, 32'h0001_00FF, 1'b1);
        host("R6", 1'b1, 32'h0001_0100, 1'b1);
        wcfg(2'd2, 32'h0);
        wcfg(2'd0, 32'h0000_5000);
        wcfg(2'd1, 32'h0000_4000);
        host("R5", 1'b1, 32'h0000_4800, 1'b0);
        host("R5", 1'b1, 32'h0000_5000, 1'b0);
    endtask

    task automatic t_regs();
        wcfg(2'd0, 32'h0000_2ABC);
        wcfg(2'd1, 32'h0000_2001);
        host("R9", 1'b1, 32'h0000_2000, 1'b1);
        host("R9", 1'b1, 32'h0000_2FFF, 1'b1);
        host("R9", 1'b1, 32'h0000_3000, 1'b0);
        wcfg(2'd3, 32'hFFFF_FFFF);
        host("R9", 1'b0, 32'h000A_0000, 1'b0);
        host("R9", 1'b1, 32'h0000_2800, 1'b1);
    endtask

    task automatic t_sec();
        wcfg(2'd2, 32'h1);
        sec("R7", 1'b0, 32'h000B_0000, 1'b1);
        sec("R7", 1'b1, 32'h0000_03D4, 1'b1);
        sec("R7", 1'b1, 32'h0000_03E0, 1'b0);
        sec("R7", 1'b0, 32'h000C_0000, 1'b0);
        wcfg(2'd2, 32'h0);
        sec("R7", 1'b0, 32'h000B_0000, 1'b0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_mem_vga();
        t_io_vga(1'b0);
        t_io_vga(1'b1);
        t_window();
        t_regs();
        t_sec();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule